// File: doc/BRIEF.md
# Write-Through Set-Associative Cache Controller

This block is the cache controller placed between a processor's request port and a slower external memory. Addresses carry a region code in their top nibble. The code decides how each access is handled. A normal cached access looks up four ways of a set. An uncached access goes straight to memory. A write to the purge region drops one line from the cache.

Every write is sent on to memory, whether or not it hits. A read miss in the cached region fetches the whole 16-byte line as one burst of eight 16-bit words. The processor holds its request stable until the controller raises `cpu_ready`. A small configuration port does three things:

- turns caching on or off;
- starts a whole-cache invalidate that clears one set per cycle;
- restricts allocation to way 0.

Top module: `wt_cache_ctrl`

## Requirements
- R1: After reset the cache is disabled, every line is invalid, `cpu_ready` is 1 with no request and `mem_req` is 0.
- R2: A cached-region read (top nibble neither 0x2 nor 0x4) that misses issues one burst (`mem_burst`=1, address aligned to 16 bytes) of eight words. Afterwards, reads of any word of that line return the filled data without a memory access.
- R3: Every write outside the purge region causes exactly one memory write (`mem_we`=1). A write that hits also updates the cached word.
- R4: A cached-region write that misses does not allocate a line, so a later read of that line issues a burst.
- R5: An access with top nibble 0x2 is a single memory access. A read there never allocates a line, and a write there leaves any cached copy unchanged.
- R6: A write with top nibble 0x4 issues no memory access and discards its data. It invalidates, in every way of the addressed set, a line whose tag matches, covering the whole 16-byte line.
- R7: Configuration bit 0 enables caching. While it is 0, cached-region accesses behave as uncached ones.
- R8: Writing 1 to configuration bit 4 invalidates all lines. `cpu_ready` stays 0 for exactly SETS+1 cycles after the write takes effect.
- R9: On a fill the lowest-numbered invalid way is used. If there is none, a 3-bit tree pseudo-LRU per set picks the victim. Bit 0 set selects the pair of ways 2/3. Bit 1 picks within ways 0/1, and bit 2 picks within ways 2/3. Hits and fills both update the tree.
- R10: With configuration bit 3 set to 1, every fill goes to way 0, so two lines of one set evict each other.
- R11: `cpu_ready` is 0 while a memory transaction is in progress, and only one memory transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration data: bit0 enable, bit3 way-0-only, bit4 invalidate all |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 32 | Byte address, top nibble is the region code |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid when cpu_ready is 1 |
| cpu_ready | output | 1 | Request completes on this cycle |
| mem_req | output | 1 | Memory transaction active |
| mem_we | output | 1 | Memory transaction is a write |
| mem_burst | output | 1 | Memory transaction is an 8-word line fill |
| mem_addr | output | 32 | Memory byte address, region code cleared |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data per beat |
| mem_ack | input | 1 | One beat accepted or delivered |

## Verification
The hardest case to reach is a stale line. The cache holds a copy that memory no longer matches, and only a purge or an invalidate brings the new value back. The stimulus first fills a line with a cached read. It then rewrites one word of that line through the uncached alias and reads it cached to show the old value is still served. Next it purges the line through the purge alias at a different offset within it, and reads the word once more to see the burst and the new value. Victim choice is reached by filling all four ways of one set, touching one of them, and counting bursts when each line is read again.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  localparam int AW         = 32;
  localparam int DW         = 16;
  localparam int WAYS       = 4;
  localparam int WAY_W      = $clog2(WAYS);
  localparam int LINE_WORDS = 8;
  localparam int WORD_W     = $clog2(LINE_WORDS);
  localparam int OFF_W      = WORD_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_MRD, ST_MWR, ST_DONE, ST_FLUSH
  } cst_t;

  typedef enum logic [1:0] {RG_CACHED, RG_UNCACHED, RG_PURGE} rgn_t;

  // tree bit0: 1 -> victim among ways 2/3; bit1/bit2 pick inside each pair
  function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [2:0] plru_mark(input logic [2:0] t,
                                           input logic [WAY_W-1:0] w);
    logic [2:0] r;
    r    = t;
    r[0] = ~w[1];
    if (w[1]) r[2] = ~w[0];
    else      r[1] = ~w[0];
    return r;
  endfunction
endpackage

// File: rtl/wtc_tag_array.sv
`timescale 1ns/1ps
module wtc_tag_array
  import wtc_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   idx,
  input  logic [TAG_W-1:0]          tag,
  input  logic                      dm_mode,
  input  logic                      fill_en,
  input  logic [WAY_W-1:0]          fill_way,
  input  logic                      touch_en,
  input  logic                      purge_en,
  input  logic                      clr_en,
  input  logic [$clog2(SETS)-1:0]   clr_idx,
  output logic                      hit,
  output logic [WAY_W-1:0]          hit_way,
  output logic [WAY_W-1:0]          victim
);
  localparam int IDX_W = $clog2(SETS);

  logic [WAYS-1:0] match;
  logic [WAYS-1:0] invalid;
  logic [2:0]      plru_q [SETS];
  logic [2:0]      plru_nx;
  logic            plru_en;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q, vld_d;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             own_fill;

    assign own_fill   = fill_en && (fill_way == WAY_W'(w));
    assign match[w]   = vld_q[idx] && (tag_q[idx] == tag);
    assign invalid[w] = ~vld_q[idx];

    always_comb begin
      vld_d = vld_q;
      if (clr_en)                     vld_d[clr_idx] = 1'b0;
      else if (purge_en && match[w])  vld_d[idx]     = 1'b0;
      else if (own_fill)              vld_d[idx]     = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (own_fill) tag_q[idx] <= tag;
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end
  assign hit = |match;

  always_comb begin
    victim = plru_pick(plru_q[idx]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (invalid[w]) victim = WAY_W'(w);
    if (dm_mode) victim = '0;
  end

  assign plru_en = fill_en || touch_en;
  assign plru_nx = plru_mark(plru_q[idx], fill_en ? fill_way : hit_way);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else if (clr_en) begin
      plru_q[clr_idx] <= '0;
    end else if (plru_en) begin
      plru_q[idx] <= plru_nx;
    end
  end

  // a line may live in at most one way of its set
  assert_one_way_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // a fill never targets a line that is already resident
  assert_fill_only_on_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !hit);

  // invalidate-all walks sets in order, one per cycle
  assert_clear_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_idx != IDX_W'(SETS - 1)) |=> (clr_en && clr_idx == $past(clr_idx) + IDX_W'(1)));
endmodule

// File: rtl/wtc_data_array.sv
`timescale 1ns/1ps
module wtc_data_array
  import wtc_pkg::*;
#(
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [WAY_W-1:0]        wway,
  input  logic [$clog2(SETS)-1:0] widx,
  input  logic [WORD_W-1:0]       wword,
  input  logic [DW-1:0]           wdata,
  input  logic [WAY_W-1:0]        rway,
  input  logic [$clog2(SETS)-1:0] ridx,
  input  logic [WORD_W-1:0]       rword,
  output logic [DW-1:0]           rdata
);
  localparam int DEPTH = WAYS * SETS * LINE_WORDS;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[{wway, widx, wword}] <= wdata;
  end

  assign rdata = store_q[{rway, ridx, rword}];
endmodule

// File: rtl/wt_cache_ctrl.sv
`timescale 1ns/1ps
module wt_cache_ctrl
  import wtc_pkg::*;
#(
  parameter int SETS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [31:0]   cpu_addr,
  input  logic [15:0]   cpu_wdata,
  output logic [15:0]   cpu_rdata,
  output logic          cpu_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_burst,
  output logic [31:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - 4 - OFF_W - IDX_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_SET  = IDX_W'(SETS - 1);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  cst_t              st_q, st_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic [WAY_W-1:0]  vic_q, vic_d;
  logic [DW-1:0]     rd_q, rd_d;
  logic [IDX_W-1:0]  fcnt_q, fcnt_d;
  logic              en_q, en_d, dm_q, dm_d, fpend_q, fpend_d;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WORD_W-1:0] word;
  logic [3:0]        region_code;
  rgn_t              rgn;
  logic              hit, chit, touch_en, fill_en, purge_en, clr_en, dwe;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [DW-1:0]     arr_rdata;

  assign idx         = cpu_addr[OFF_W +: IDX_W];
  assign tag         = cpu_addr[AW-5 -: TAG_W];
  assign word        = cpu_addr[OFF_W-1:1];
  assign region_code = cpu_addr[AW-1 -: 4];

  always_comb begin
    if (cpu_we && region_code == 4'h4)                  rgn = RG_PURGE;
    else if (region_code == 4'h2 || region_code == 4'h4 || !en_q) rgn = RG_UNCACHED;
    else                                                rgn = RG_CACHED;
  end
  assign chit = (rgn == RG_CACHED) && hit;

  wtc_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .idx      (idx),
    .tag      (tag),
    .dm_mode  (dm_q),
    .fill_en  (fill_en),
    .fill_way (vic_q),
    .touch_en (touch_en),
    .purge_en (purge_en),
    .clr_en   (clr_en),
    .clr_idx  (fcnt_q),
    .hit      (hit),
    .hit_way  (hit_way),
    .victim   (victim)
  );

  wtc_data_array #(.SETS(SETS)) u_data (
    .clk   (clk),
    .we    (dwe),
    .wway  ((st_q == ST_FILL) ? vic_q : hit_way),
    .widx  (idx),
    .wword ((st_q == ST_FILL) ? beat_q : word),
    .wdata ((st_q == ST_FILL) ? mem_rdata : cpu_wdata),
    .rway  (hit_way),
    .ridx  (idx),
    .rword (word),
    .rdata (arr_rdata)
  );

  always_comb begin
    st_d = st_q;  beat_d = beat_q;  vic_d = vic_q;  rd_d = rd_q;
    fcnt_d = fcnt_q;  fpend_d = fpend_q;  en_d = en_q;  dm_d = dm_q;
    cpu_ready = 1'b0;  touch_en = 1'b0;  fill_en = 1'b0;
    purge_en = 1'b0;   clr_en = 1'b0;    dwe = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fpend_q) begin
          st_d = ST_FLUSH;  fcnt_d = '0;  fpend_d = 1'b0;
        end else if (!cpu_req) begin
          cpu_ready = 1'b1;
        end else if (rgn == RG_PURGE) begin
          purge_en = 1'b1;  cpu_ready = 1'b1;
        end else if (cpu_we) begin
          st_d = ST_MWR;
          if (chit) begin dwe = 1'b1; touch_en = 1'b1; end
        end else if (rgn == RG_CACHED) begin
          if (hit) begin
            cpu_ready = 1'b1;  touch_en = 1'b1;
          end else begin
            st_d = ST_FILL;  beat_d = '0;  vic_d = victim;
          end
        end else begin
          st_d = ST_MRD;
        end
      end
      ST_FILL: if (mem_ack) begin
        dwe    = 1'b1;
        beat_d = beat_q + WORD_W'(1);
        if (beat_q == LAST_BEAT) begin fill_en = 1'b1; st_d = ST_IDLE; end
      end
      ST_MRD:  if (mem_ack) begin rd_d = mem_rdata; st_d = ST_DONE; end
      ST_MWR:  if (mem_ack) st_d = ST_DONE;
      ST_DONE: begin cpu_ready = 1'b1; st_d = ST_IDLE; end
      ST_FLUSH: begin
        clr_en = 1'b1;
        fcnt_d = fcnt_q + IDX_W'(1);
        if (fcnt_q == LAST_SET) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (cfg_we) begin
      en_d = cfg_wdata[0];
      dm_d = cfg_wdata[3];
      if (cfg_wdata[4]) fpend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= ST_IDLE;  en_q <= 1'b0;  dm_q <= 1'b0;  fpend_q <= 1'b0;
      fcnt_q <= '0;
    end else begin
      st_q <= st_d;  en_q <= en_d;  dm_q <= dm_d;  fpend_q <= fpend_d;
      fcnt_q <= fcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    beat_q <= beat_d;
    vic_q  <= vic_d;
    rd_q   <= rd_d;
  end

  assign cpu_rdata = (st_q == ST_DONE) ? rd_q : arr_rdata;
  assign mem_req   = (st_q == ST_FILL) || (st_q == ST_MRD) || (st_q == ST_MWR);
  assign mem_we    = (st_q == ST_MWR);
  assign mem_burst = (st_q == ST_FILL);
  assign mem_addr  = (st_q == ST_FILL) ? {4'h0, cpu_addr[AW-5:OFF_W], {OFF_W{1'b0}}}
                                       : {4'h0, cpu_addr[AW-5:0]};
  assign mem_wdata = cpu_wdata;

  assert_purge_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_IDLE && !fpend_q && cpu_req && cpu_we && region_code == 4'h4) |=> !mem_req);

  assert_bypass_no_fill_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && mem_burst) |-> (region_code != 4'h2));

  assert_stall_mem_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req |-> !cpu_ready);

  assert_write_done_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && mem_we && mem_ack) |=> (cpu_ready && !mem_req));

  assert_flush_stall_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_we && cfg_wdata[4]) |=> !cpu_ready);
endmodule

// File: tb/wt_cache_ctrl_tb.sv
`timescale 1ns/1ps
module wt_cache_ctrl_tb;
  localparam int SETS = 16;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [15:0] wd;
    logic        chk;
    logic [15:0] exp;
    logic [3:0]  db;   // expected burst count delta
    logic [3:0]  dw;   // expected memory write delta
    logic [3:0]  rq;
  } vec_t;

  // memory word at halfword index i starts as 16'h1000 + i
  localparam vec_t VEC [15] = '{
    '{1'b0, 32'h0000_0040, 16'h0,    1'b1, 16'h1020, 4'd1, 4'd0, 4'd2},  // R2 miss fill
    '{1'b0, 32'h0000_0046, 16'h0,    1'b1, 16'h1023, 4'd0, 4'd0, 4'd2},  // R2 hit
    '{1'b1, 32'h0000_0044, 16'hBEEF, 1'b0, 16'h0,    4'd0, 4'd1, 4'd3},  // R3 write hit
    '{1'b0, 32'h0000_0044, 16'h0,    1'b1, 16'hBEEF, 4'd0, 4'd0, 4'd3},  // R3 cached word updated
    '{1'b1, 32'h0000_00A0, 16'h1111, 1'b0, 16'h0,    4'd0, 4'd1, 4'd4},  // R4 write miss
    '{1'b0, 32'h0000_00A0, 16'h0,    1'b1, 16'h1111, 4'd1, 4'd0, 4'd4},  // R4 no allocate
    '{1'b0, 32'h2000_0080, 16'h0,    1'b1, 16'h1040, 4'd0, 4'd0, 4'd5},  // R5 bypass read
    '{1'b0, 32'h2000_0080, 16'h0,    1'b1, 16'h1040, 4'd0, 4'd0, 4'd5},  // R5 again
    '{1'b0, 32'h0000_0080, 16'h0,    1'b1, 16'h1040, 4'd1, 4'd0, 4'd5},  // R5 never allocated
    '{1'b1, 32'h2000_0046, 16'h2222, 1'b0, 16'h0,    4'd0, 4'd1, 4'd5},  // R5 bypass write
    '{1'b0, 32'h0000_0046, 16'h0,    1'b1, 16'h1023, 4'd0, 4'd0, 4'd5},  // R5 stale copy kept
    '{1'b1, 32'h4000_004E, 16'hDEAD, 1'b0, 16'h0,    4'd0, 4'd0, 4'd6},  // R6 purge
    '{1'b0, 32'h2000_004E, 16'h0,    1'b1, 16'h1027, 4'd0, 4'd0, 4'd6},  // R6 data discarded
    '{1'b0, 32'h0000_0046, 16'h0,    1'b1, 16'h2222, 4'd1, 4'd0, 4'd6},  // R6 line refetched
    '{1'b0, 32'h0000_0040, 16'h0,    1'b1, 16'h1020, 4'd0, 4'd0, 4'd6}   // R6 refilled line hits
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we, mem_burst, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int bad_stall = 0;
  int nb = 0, nw = 0, nr = 0;

  always #2.5 clk = ~clk;

  wt_cache_ctrl #(.SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  // memory model: 3 wait cycles, then one beat per cycle
  logic [15:0] mem [1024];
  logic        m_busy, m_we, m_burst;
  int          m_cnt;
  logic [9:0]  m_idx;
  logic [15:0] m_wd;
  logic [9:0]  m_rd_idx;

  assign mem_ack   = m_busy && (m_cnt >= 3);
  assign m_rd_idx  = m_burst ? (m_idx + 10'(m_cnt - 3)) : m_idx;
  assign mem_rdata = mem[m_rd_idx];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;  m_cnt <= 0;  m_we <= 1'b0;  m_burst <= 1'b0;
      m_idx <= '0;  m_wd <= '0;
      for (int i = 0; i < 1024; i++) mem[i] <= 16'h1000 + 16'(i);
    end else if (m_busy) begin
      if (mem_ack && (!m_burst || m_cnt == 10)) begin
        m_busy <= 1'b0;
        if (m_we) mem[m_idx] <= m_wd;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end else if (mem_req) begin
      m_busy <= 1'b1;  m_cnt <= 0;  m_we <= mem_we;  m_burst <= mem_burst;
      m_idx <= mem_addr[10:1];  m_wd <= mem_wdata;
      if (mem_burst)   nb <= nb + 1;
      else if (mem_we) nw <= nw + 1;
      else             nr <= nr + 1;
    end
  end

  always @(negedge clk) if (cpu_ready && m_busy) bad_stall <= bad_stall + 1;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [31:0] a,
                       input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    cpu_req = 1'b1;  cpu_we = wr;  cpu_addr = a;  cpu_wdata = wd;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;  cpu_we = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] d, output int low_cycles);
    @(negedge clk);
    cfg_we = 1'b1;  cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    low_cycles = 0;
    while (!cpu_ready) begin low_cycles++; @(negedge clk); #1; end
  endtask

  task automatic rd_expect(input string req, input logic [31:0] a, input int exp_b);
    logic [15:0] rd;
    int b0;
    b0 = nb;
    do_op(1'b0, a, 16'h0, rd);
    check(req, "burst count", 32'(nb - b0), 32'(exp_b));
    check(req, "read data", 32'(rd), 32'(mem[a[10:1]]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int lc, b0, w0, r0;
    rst_n = 1'b0;  cfg_we = 1'b0;  cfg_wdata = '0;
    cpu_req = 1'b0;  cpu_we = 1'b0;  cpu_addr = '0;  cpu_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "cpu_ready", 32'(cpu_ready), 32'd1);
    check("R1", "mem_req", 32'(mem_req), 32'd0);
    // R1/R7: disabled after reset, cached region goes straight to memory
    b0 = nb;  r0 = nr;
    do_op(1'b0, 32'h0000_0070, 16'h0, rd);
    check("R7", "burst while disabled", 32'(nb - b0), 32'd0);
    check("R7", "single read while disabled", 32'(nr - r0), 32'd1);
    check("R7", "data while disabled", 32'(rd), 32'h1038);

    // R8 enable with invalidate: stall SETS+1 cycles
    cfg_write(8'h11, lc);
    check("R8", "invalidate stall cycles", 32'(lc), 32'(SETS + 1));

    foreach (VEC[i]) begin
      b0 = nb;  w0 = nw;
      do_op(VEC[i].wr, VEC[i].addr, VEC[i].wd, rd);
      check($sformatf("R%0d", VEC[i].rq), $sformatf("row %0d bursts", i),
            32'(nb - b0), 32'(VEC[i].db));
      check($sformatf("R%0d", VEC[i].rq), $sformatf("row %0d mem writes", i),
            32'(nw - w0), 32'(VEC[i].dw));
      if (VEC[i].chk)
        check($sformatf("R%0d", VEC[i].rq), $sformatf("row %0d data", i),
              32'(rd), 32'(VEC[i].exp));
    end

    // R9: fill four ways of set 5, touch way 0, fifth line evicts way 2
    rd_expect("R9", 32'h0000_0050, 1);
    rd_expect("R9", 32'h0000_0150, 1);
    rd_expect("R9", 32'h0000_0250, 1);
    rd_expect("R9", 32'h0000_0350, 1);
    rd_expect("R9", 32'h0000_0050, 0);
    rd_expect("R9", 32'h0000_0450, 1);
    rd_expect("R9", 32'h0000_0052, 0);
    rd_expect("R9", 32'h0000_0154, 0);
    rd_expect("R9", 32'h0000_0356, 0);
    rd_expect("R9", 32'h0000_0458, 0);
    rd_expect("R9", 32'h0000_0250, 1);

    // R8: invalidate-all empties the cache
    cfg_write(8'h11, lc);
    check("R8", "second invalidate stall", 32'(lc), 32'(SETS + 1));
    rd_expect("R8", 32'h0000_0450, 1);

    // R10: way-0-only allocation makes two lines of a set collide
    cfg_write(8'h19, lc);
    rd_expect("R10", 32'h0000_0060, 1);
    rd_expect("R10", 32'h0000_0160, 1);
    rd_expect("R10", 32'h0000_0060, 1);
    rd_expect("R10", 32'h0000_0060, 0);

    // R7: disabling again turns cached accesses into single ones
    cfg_write(8'h00, lc);
    check("R7", "no stall without invalidate", 32'(lc), 32'd0);
    b0 = nb;  r0 = nr;  w0 = nw;
    do_op(1'b0, 32'h0000_0060, 16'h0, rd);
    do_op(1'b1, 32'h0000_0062, 16'h3333, rd);
    check("R7", "burst while disabled", 32'(nb - b0), 32'd0);
    check("R7", "single read while disabled", 32'(nr - r0), 32'd1);
    check("R3", "write while disabled", 32'(nw - w0), 32'd1);
    rd_expect("R7", 32'h2000_0062, 0);

    check("R11", "ready seen while memory busy", 32'(bad_stall), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule